// File: doc/BRIEF.md
# Signed Fixed-Point Multiplier with Rounding and Clamping

The block multiplies two signed fixed-point operands that share one format. Each operand holds an integer whose real value is that integer times 2^-F, where F is the number of fractional bits. The total width is one sign bit, plus the integer bits, plus F. The two N-bit operands produce an exact 2N-bit product. The product is then shifted back to the operand format, either by plain truncation or by round-to-nearest. Any result that falls outside the signed N-bit range is clamped to the nearest limit. It never wraps around.

One operation can be accepted on every clock cycle. The result, a clamp flag and an output strobe come out of a single register stage, one cycle after the input strobe. With the default parameters, the operands are 16-bit values with 15 fractional bits, a signed format that is common in DSP arithmetic. A design that needs more integer range, such as 12 fractional bits, changes only the parameter.

Top module: `qmul_core`

## Requirements
- R1: While rst_ni is low, valid_o, res_o and sat_o are all 0.
- R2: valid_o is 1 in the cycle after a clock edge that sampled valid_i = 1, and 0 after an edge that sampled valid_i = 0. Back-to-back operations are accepted on consecutive cycles.
- R3: With round_i = 0 (truncate), the unclamped result is floor(a*b / 2^F). This is the arithmetic right shift of the full 2N-bit product by F, so the error is below one output LSB.
- R4: With round_i = 1 (nearest), the unclamped result is floor((a*b + 2^(F-1)) / 2^F). The error is at most half an output LSB, and exact ties round toward positive infinity.
- R5: An unclamped result above 2^(N-1)-1 gives res_o = 0x7FFF at N = 16 (all ones below a 0 sign bit), with sat_o = 1.
- R6: An unclamped result below -2^(N-1) gives res_o = 0x8000 at N = 16 (a 1 sign bit over zeros), with sat_o = 1.
- R7: For any result that is within range, sat_o = 0 and res_o carries the unclamped value exactly.
- R8: res_o never shows a wrapped polarity. Operands of equal sign give a result with res_o[N-1] = 0. Operands of opposite sign give a negative or zero result.
- R9: A clock edge that samples valid_i = 0 leaves res_o and sat_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | DATA_W | First signed operand |
| b_i | input | DATA_W | Second signed operand |
| round_i | input | 1 | 1 selects round-to-nearest, 0 selects truncation |
| valid_o | output | 1 | Result is valid |
| res_o | output | DATA_W | Rescaled, clamped result |
| sat_o | output | 1 | Result was clamped |

## Verification
The datapath has only one register stage, so any wrong internal value shows up at res_o or sat_o in the cycle right after the faulty operation. It never stays hidden for long.

- An extension bit or rounding offset that is off by one shows up as an LSB error on exact ties and negative products. The directed cases target exactly those.
- A faulty overflow test shows up either as a wrapped code of the wrong sign, or as a flag that does not match a limit code.

A second instance with fewer fractional bits is needed to reach the negative clamp, because with one integer bit only the positive clamp is reachable.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_NEAR  = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/qmul_product.sv
module qmul_product #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic signed [PROD_W-1:0] prod_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext  = PROD_W'(a_i);
    b_ext  = PROD_W'(b_i);
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/qmul_rescale.sv
module qmul_rescale
  import qmul_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 15,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned EXT_W  = PROD_W + 1,
  localparam int unsigned SCL_W  = EXT_W - FRAC_W
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  rnd_mode_e                mode_i,
  output logic signed [SCL_W-1:0]  scaled_o
);
  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] biased;

  // extra sign bit keeps the rounding add from overflowing
  assign ext = {prod_i[PROD_W-1], prod_i};

  generate
    if (FRAC_W == 0) begin : g_no_frac
      assign biased = ext;
    end else begin : g_frac
      localparam logic [EXT_W-1:0] HALF_LSB = EXT_W'(1) << (FRAC_W - 1);
      assign biased = ext + ((mode_i == RND_NEAR) ? HALF_LSB : '0);
    end
  endgenerate

  // slicing off FRAC_W low bits is floor division by 2^F
  assign scaled_o = biased[EXT_W-1:FRAC_W];
endmodule

// File: rtl/qmul_saturate.sv
module qmul_saturate #(
  parameter int unsigned IN_W  = 18,
  parameter int unsigned OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  val_i,
  output logic signed [OUT_W-1:0] res_o,
  output logic                    sat_o
);
  localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic [IN_W-OUT_W:0] top_bits;
  logic                in_range;

  assign top_bits = val_i[IN_W-1:OUT_W-1];
  // in range when every bit above the result's sign bit agrees with it
  assign in_range = (top_bits == '0) || (top_bits == '1);

  always_comb begin
    sat_o = ~in_range;
    if (in_range)           res_o = val_i[OUT_W-1:0];
    else if (val_i[IN_W-1]) res_o = MIN_CODE;
    else                    res_o = MAX_CODE;
  end
endmodule

// File: rtl/qmul_core.sv
module qmul_core
  import qmul_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              round_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;
  localparam int unsigned SCL_W  = PROD_W + 1 - FRAC_W;
  localparam logic [DATA_W-1:0] MAX_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [SCL_W-1:0]  scaled;
  logic signed [DATA_W-1:0] res_d;
  logic                     sat_d;

  qmul_product #(.DATA_W(DATA_W)) u_prod (
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  qmul_rescale #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_rescale (
    .prod_i  (prod),
    .mode_i  (rnd_mode_e'(round_i)),
    .scaled_o(scaled)
  );

  qmul_saturate #(.IN_W(SCL_W), .OUT_W(DATA_W)) u_sat (
    .val_i(scaled),
    .res_o(res_d),
    .sat_o(sat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o <= res_d;
        sat_o <= sat_d;
      end
    end
  end

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o)));
  assert_sat_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> (res_o == MAX_CODE || res_o == MIN_CODE));
  assert_same_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_i[DATA_W-1] == b_i[DATA_W-1])) |=> !res_o[DATA_W-1]);
  assert_diff_sign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (a_i[DATA_W-1] != b_i[DATA_W-1])) |=> (res_o[DATA_W-1] || res_o == '0));
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0 && !sat_o));
endmodule

// File: tb/qmul_core_test.sv
`timescale 1ns/1ps
module qmul_core_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        round_i = 1'b0;
  logic        valid_o, sat_o, valid_q3, sat_q3;
  logic [15:0] res_o, res_q3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  qmul_core #(.DATA_W(16), .FRAC_W(15)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .round_i(round_i), .valid_o(valid_o), .res_o(res_o), .sat_o(sat_o));

  qmul_core #(.DATA_W(16), .FRAC_W(12)) uut_q3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .round_i(round_i), .valid_o(valid_q3), .res_o(res_q3), .sat_o(sat_q3));

  // returns {sat, res}
  function automatic logic [16:0] model(logic [15:0] a, logic [15:0] b, bit rnd, int f);
    longint p, q;
    p = longint'($signed(a)) * longint'($signed(b));
    if (rnd && f > 0) p = p + (longint'(1) <<< (f - 1));
    q = p >>> f;
    if (q > 32767)       return {1'b1, 16'h7FFF};
    else if (q < -32768) return {1'b1, 16'h8000};
    else                 return {1'b0, q[15:0]};
  endfunction

  task automatic check(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual valid/sat/res=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue at negedge, result registered at next posedge, compared at following negedge
  task automatic op(logic [15:0] a, logic [15:0] b, bit rnd, string tag);
    logic [16:0] e15, e12;
    a_i = a; b_i = b; round_i = rnd; valid_i = 1'b1;
    e15 = model(a, b, rnd, 15);
    e12 = model(a, b, rnd, 12);
    @(negedge clk_i);
    check({tag, " q15"}, {valid_o, sat_o, res_o}, {1'b1, e15});
    check({tag, " q12"}, {valid_q3, sat_q3, res_q3}, {1'b1, e12});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [17:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1 reset", {valid_o, sat_o, res_o}, 18'h0);
    check("R1 reset q12", {valid_q3, sat_q3, res_q3}, 18'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    op(16'h4000, 16'h4000, 1'b0, "R3 quarter");
    op(16'h0001, 16'h4000, 1'b0, "R3 tie trunc");
    op(16'h0001, 16'h4000, 1'b1, "R4 tie round up");
    op(16'hFFFF, 16'h4000, 1'b0, "R3 neg floor");
    op(16'hFFFF, 16'h4000, 1'b1, "R4 neg tie to zero");
    op(16'h7FFF, 16'h7FFF, 1'b1, "R7 max squared");
    op(16'h8000, 16'h8000, 1'b0, "R5 clamp pos");
    op(16'h8000, 16'h8000, 1'b1, "R5 clamp pos round");
    op(16'h8000, 16'h7FFF, 1'b0, "R6 clamp neg");
    op(16'h7FFF, 16'h7FFF, 1'b0, "R5 q12 clamp pos");
    op(16'h8000, 16'h0001, 1'b1, "R8 mixed sign");
    op(16'h0000, 16'h8000, 1'b1, "R7 zero");

    // R9: idle cycle with new operands must not move the outputs
    held = {1'b1, sat_o, res_o};
    valid_i = 1'b0; a_i = 16'h1234; b_i = 16'h7FFF; round_i = 1'b1;
    @(negedge clk_i);
    check("R2 idle valid", {17'h0, valid_o}, 18'h0);
    check("R9 hold", {1'b1, sat_o, res_o}, held);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      op(r[15:0], r[31:16], r[0] ^ r[17], "R2/R3/R4/R7 random");
    end
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R2 drain", {17'h0, valid_o}, 18'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule